// File: doc/BRIEF.md
# Dot-Clock Source Selector and Video-Clock Divider

This block picks the internal dot clock from a set of candidate clocks (three single-ended inputs, a differential pair and a PLL output) and derives a video clock from it. The video clock is the dot clock divided by a power of two between 1 and 64, or it is held low. A second output, the shift clock, is the dot clock passed through a gate that software controls. One 8-bit selection register controls all of this. Software reaches the register through an indexed port in the system clock domain: an index strobe loads the index, then data strobes write or read the register at that index.

Source decoding is combinational on the register value. The divide code and the shift-clock enable cross into the dot-clock domain through two-flop synchronizers. The divider accepts a new code only after two equal synchronized samples. When it accepts a new code it restarts its counter from zero, so every new ratio begins from a clean phase.

Top module: `dotclk_sel`

## Requirements
- R1: After reset the selection register, read at index 0x1A, returns 0x07 (source code 0111, divide code 000, shift clock off).
- R2: An index strobe loads `wdata` as the index. A data write strobe then loads the register only when the index is 0x1A. A read strobe places the register value on `rdata` one clock later, or 0 when the index is not 0x1A.
- R3: Bits 6:4 values 000 to 110 make `vid_clk` the dot clock divided by 2 to the power of that value (1, 2, 4, 8, 16, 32, 64).
- R4: For every ratio above 1, `vid_clk` is high for exactly half of its period.
- R5: Bits 6:4 equal to 111 hold `vid_clk` at 0.
- R6: A new divide code takes effect about four dot-clock edges after the write. At that point the counter restarts at zero with `vid_clk` low, so the first rising edge comes one half-period of the new ratio later.
- R7: Bits 3:0 select the dot-clock source: 0000 and 0111 select `clk_in0`; 0001 selects `clk_in1`; 0010 and 0011 select `clk_in2`; 0100 selects the differential pair (`clk_diff_p` high while `clk_diff_n` low); 0101 selects `clk_pll`.
- R8: Source code 0110, and any source code with bit 3 set, stop the dot clock. While the dot clock is stopped, `dot_clk` and `vid_clk` stay at 0, and readback still returns the written value.
- R9: Bit 7 set makes `sclk_out` follow the dot clock. Bit 7 clear holds `sclk_out` at 0.
- R10: `alt_latch` is 1 exactly when the source code is 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| idx_wr | input | 1 | Index strobe: loads wdata as index |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe |
| wdata | input | 8 | Index or write data |
| rdata | output | 8 | Registered read data |
| clk_in0 | input | 1 | Candidate clock 0 |
| clk_in1 | input | 1 | Candidate clock 1 |
| clk_in2 | input | 1 | Candidate clock 2, single-ended |
| clk_diff_p | input | 1 | Differential candidate clock, true side |
| clk_diff_n | input | 1 | Differential candidate clock, complement side |
| clk_pll | input | 1 | PLL output used as a candidate clock |
| dot_clk | output | 1 | Selected dot clock |
| vid_clk | output | 1 | Divided video clock |
| sclk_out | output | 1 | Gated shift clock |
| alt_latch | output | 1 | Alternate-latching-mode flag |

## Verification
The hardest case to reach from the ports is the divider restart. The new code must cross two synchronizer stages and pass the stability filter before the counter clears, and a divider that skips the restart still produces the correct steady-state period. The bench first runs the divider at ratio 2 and then writes ratio 64. It records the system-clock edge that captures the write and measures the time to the first rising edge of `vid_clk` that follows the old-ratio edges. That time must fall inside a window of about 36 dot periods, which only a restarted counter produces.

// File: rtl/dotclk_sel_pkg.sv
`timescale 1ns/1ps
package dotclk_sel_pkg;
  localparam int REG_W    = 8;
  localparam int DIV_W    = 3;
  localparam int SRC_W    = 4;
  localparam int MAX_LOG2 = 6;
  localparam int CNT_W    = $clog2(1 << (MAX_LOG2 - 1)) + 1;

  typedef enum logic [2:0] {
    SRC_IN0, SRC_IN1, SRC_IN2, SRC_DIFF, SRC_PLL, SRC_OFF
  } src_e;

  function automatic src_e decode_src(logic [SRC_W-1:0] code);
    case (code)
      4'b0000, 4'b0111: return SRC_IN0;
      4'b0001:          return SRC_IN1;
      4'b0010, 4'b0011: return SRC_IN2;
      4'b0100:          return SRC_DIFF;
      4'b0101:          return SRC_PLL;
      default:          return SRC_OFF;
    endcase
  endfunction

  // Half-period in dot-clock cycles; 0 means no counting (ratio 1 or held low).
  function automatic logic [CNT_W-1:0] half_period(logic [DIV_W-1:0] code);
    if (code == '0 || code == '1) return '0;
    return CNT_W'(1) << (code - 3'd1);
  endfunction

  function automatic logic is_alt(logic [SRC_W-1:0] code);
    return code == 4'b0111;
  endfunction
endpackage

// File: rtl/dotclk_sel_regs.sv
`timescale 1ns/1ps
module dotclk_sel_regs #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] REG_IDX   = 8'h1A,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] sel_q
);
  logic [DATA_W-1:0] idx_q;
  logic              hit;

  assign hit = (idx_q == REG_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= RESET_VAL;
      rdata <= '0;
    end else begin
      if (idx_wr)         idx_q <= wdata;
      if (data_wr && hit) sel_q <= wdata;
      if (data_rd)        rdata <= hit ? sel_q : '0;
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && hit) |=> sel_q == $past(wdata));
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && hit) |=> $stable(sel_q));
  a_r2_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && hit) |=> rdata == $past(sel_q));
  a_r2_read_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !hit) |=> rdata == '0);
endmodule

// File: rtl/dotclk_sel_srcmux.sv
`timescale 1ns/1ps
module dotclk_sel_srcmux
  import dotclk_sel_pkg::*;
(
  input  logic [SRC_W-1:0] src_code,
  input  logic             clk_in0,
  input  logic             clk_in1,
  input  logic             clk_in2,
  input  logic             clk_diff_p,
  input  logic             clk_diff_n,
  input  logic             clk_pll,
  output logic             dot_clk,
  output logic             dot_off,
  output logic             alt_latch
);
  src_e sel;
  logic diff_rx;

  assign sel       = decode_src(src_code);
  assign diff_rx   = clk_diff_p & ~clk_diff_n;
  assign dot_off   = (sel == SRC_OFF);
  assign alt_latch = is_alt(src_code);

  always_comb begin
    case (sel)
      SRC_IN0:  dot_clk = clk_in0;
      SRC_IN1:  dot_clk = clk_in1;
      SRC_IN2:  dot_clk = clk_in2;
      SRC_DIFF: dot_clk = diff_rx;
      SRC_PLL:  dot_clk = clk_pll;
      default:  dot_clk = 1'b0;
    endcase
  end
endmodule

// File: rtl/dotclk_sel_divider.sv
`timescale 1ns/1ps
module dotclk_sel_divider
  import dotclk_sel_pkg::*;
(
  input  logic             dot_clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code_async,
  input  logic             sclk_en_async,
  output logic             vid_raw,
  output logic             sclk_out,
  output logic             code_change
);
  logic [DIV_W-1:0] s1_q, s2_q, s3_q, app_q;
  logic [1:0]       en_sync_q;
  logic [CNT_W-1:0] cnt_q, half_now;
  logic             div_q, pass_q, sgate_q, terminal;

  assign half_now    = half_period(app_q);
  assign code_change = (s2_q == s3_q) && (s2_q != app_q);
  assign terminal    = (half_now != '0) && (cnt_q == half_now - 1'b1);

  always_ff @(posedge dot_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0; app_q <= '0;
      en_sync_q <= '0;
      cnt_q <= '0; div_q <= 1'b0;
    end else begin
      s1_q <= div_code_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
      en_sync_q <= {en_sync_q[0], sclk_en_async};
      if (code_change) begin
        app_q <= s2_q;
        cnt_q <= '0;
        div_q <= 1'b0;
      end else if (half_now == '0) begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end else if (terminal) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Gates change while the dot clock is low, so gated outputs cannot glitch.
  always_ff @(negedge dot_clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q  <= 1'b0;
      sgate_q <= 1'b0;
    end else begin
      pass_q  <= (app_q == '0);
      sgate_q <= en_sync_q[1];
    end
  end

  assign vid_raw  = (dot_clk & pass_q) | div_q;
  assign sclk_out = dot_clk & sgate_q;

  a_r4_cnt_bound: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (half_now != '0) |-> cnt_q < half_now);
  a_r4_toggle: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (terminal && !code_change) |=> div_q != $past(div_q));
  a_r5_hold_low: assert property (@(posedge dot_clk) disable iff (!rst_n)
    (app_q == '1) |-> !div_q);
  a_r6_clean_phase: assert property (@(posedge dot_clk) disable iff (!rst_n)
    code_change |=> (cnt_q == '0) && !div_q);
endmodule

// File: rtl/dotclk_sel.sv
`timescale 1ns/1ps
module dotclk_sel
  import dotclk_sel_pkg::*;
#(
  parameter logic [REG_W-1:0] REG_IDX   = 8'h1A,
  parameter logic [REG_W-1:0] RESET_VAL = 8'h07
) (
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             clk_in0,
  input  logic             clk_in1,
  input  logic             clk_in2,
  input  logic             clk_diff_p,
  input  logic             clk_diff_n,
  input  logic             clk_pll,
  output logic             dot_clk,
  output logic             vid_clk,
  output logic             sclk_out,
  output logic             alt_latch
);
  logic [REG_W-1:0] sel_q;
  logic             dot_off, vid_raw, code_change;

  dotclk_sel_regs #(.DATA_W(REG_W), .REG_IDX(REG_IDX), .RESET_VAL(RESET_VAL)) u_regs (
    .clk(sys_clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .sel_q(sel_q)
  );

  dotclk_sel_srcmux u_mux (
    .src_code(sel_q[SRC_W-1:0]), .clk_in0(clk_in0), .clk_in1(clk_in1),
    .clk_in2(clk_in2), .clk_diff_p(clk_diff_p), .clk_diff_n(clk_diff_n),
    .clk_pll(clk_pll), .dot_clk(dot_clk), .dot_off(dot_off), .alt_latch(alt_latch)
  );

  dotclk_sel_divider u_div (
    .dot_clk(dot_clk), .rst_n(rst_n),
    .div_code_async(sel_q[SRC_W +: DIV_W]), .sclk_en_async(sel_q[REG_W-1]),
    .vid_raw(vid_raw), .sclk_out(sclk_out), .code_change(code_change)
  );

  // A stopped dot clock can freeze the divider high; force the output low.
  assign vid_clk = vid_raw & ~dot_off;

  a_r8_off_low: assert property (@(posedge sys_clk) disable iff (!rst_n)
    dot_off |-> !vid_clk && !dot_clk && !sclk_out);
  a_r10_alt_flag: assert property (@(posedge sys_clk) disable iff (!rst_n)
    alt_latch |-> !dot_off);
endmodule

// File: tb/dotclk_sel_tb.sv
`timescale 1ns/1ps
module dotclk_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam real P0 = 8.0, P1 = 12.0, P2 = 6.0, PD = 14.0, PP = 4.0;

  logic sys_clk = 0, rst_n = 0, idx_wr = 0, data_wr = 0, data_rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic clk_in0 = 0, clk_in1 = 0, clk_in2 = 0, clk_diff_p = 0, clk_diff_n = 1, clk_pll = 0;
  logic dot_clk, vid_clk, sclk_out, alt_latch;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #(P0/2) clk_in0 = ~clk_in0;
  always #(P1/2) clk_in1 = ~clk_in1;
  always #(P2/2) clk_in2 = ~clk_in2;
  always #(PD/2) begin clk_diff_p = ~clk_diff_p; clk_diff_n = ~clk_diff_n; end
  always #(PP/2) clk_pll = ~clk_pll;

  dotclk_sel u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] val);
    @(negedge sys_clk); idx_wr = 1; wdata = idx;
    @(negedge sys_clk); idx_wr = 0; data_wr = 1; wdata = val;
    @(negedge sys_clk); data_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] val);
    @(negedge sys_clk); idx_wr = 1; wdata = idx;
    @(negedge sys_clk); idx_wr = 0; data_rd = 1;
    @(negedge sys_clk); data_rd = 0; val = rdata;
  endtask

  task automatic vid_period(output real p);
    real t1;
    repeat (4) @(posedge vid_clk);
    t1 = $realtime;
    @(posedge vid_clk);
    p = $realtime - t1;
  endtask

  task automatic count_high(output int n);
    n = 0;
    #100;
    for (int i = 0; i < 400; i++) begin
      #1.3;
      if (vid_clk || dot_clk) n++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v; real p;
    rd_reg(8'h1A, v);
    chk(v == 8'h07, "R1", "reset value", v, 8'h07);
    chk(alt_latch == 1'b1, "R10", "alt flag at reset", alt_latch, 1);
    vid_period(p);
    chk(p > P0 - 0.5 && p < P0 + 0.5, "R7", "reset source period", p, P0);
  endtask

  task automatic t_regport;
    logic [7:0] v;
    wr_reg(8'h05, 8'hAA);
    rd_reg(8'h1A, v);
    chk(v == 8'h07, "R2", "write at other index ignored", v, 8'h07);
    rd_reg(8'h05, v);
    chk(v == 8'h00, "R2", "read at other index", v, 0);
    wr_reg(8'h1A, 8'h31);
    rd_reg(8'h1A, v);
    chk(v == 8'h31, "R2", "readback", v, 8'h31);
  endtask

  task automatic t_sources;
    logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5};
    real exps [6] = '{P0, P1, P2, P2, PD, PP};
    real p;
    for (int i = 0; i < 6; i++) begin
      wr_reg(8'h1A, {4'h0, codes[i]});
      vid_period(p);
      chk(p > exps[i] - 0.5 && p < exps[i] + 0.5, "R7", $sformatf("source %0d period", codes[i]), p, exps[i]);
      chk(alt_latch == 1'b0, "R10", "alt flag low", alt_latch, 0);
    end
  endtask

  task automatic t_ratios;
    real p, t1, hi, exp;
    for (int k = 0; k < 7; k++) begin
      wr_reg(8'h1A, {1'b0, 3'(k), 4'h2});
      vid_period(p);
      exp = P2 * (1 << k);
      chk(p > exp - 0.5 && p < exp + 0.5, "R3", $sformatf("ratio code %0d period", k), p, exp);
      if (k > 0) begin
        @(posedge vid_clk); t1 = $realtime;
        @(negedge vid_clk); hi = $realtime - t1;
        chk(hi > exp/2 - 0.5 && hi < exp/2 + 0.5, "R4", "high time", hi, exp/2);
      end
    end
  endtask

  task automatic t_stuck;
    int n; logic [7:0] v;
    wr_reg(8'h1A, 8'h72);
    #100; n = 0;
    for (int i = 0; i < 400; i++) begin #1.3; if (vid_clk) n++; end
    chk(n == 0, "R5", "code 111 holds video low", n, 0);
    wr_reg(8'h1A, 8'h16);
    count_high(n);
    chk(n == 0, "R8", "source 0110 stops clocks", n, 0);
    wr_reg(8'h1A, 8'h09);
    count_high(n);
    chk(n == 0, "R8", "reserved source stops clocks", n, 0);
    rd_reg(8'h1A, v);
    chk(v == 8'h09, "R8", "reserved readback", v, 8'h09);
  endtask

  task automatic t_sclk;
    int n; real t1, p;
    wr_reg(8'h1A, 8'h82);
    repeat (4) @(posedge sclk_out);
    t1 = $realtime; @(posedge sclk_out); p = $realtime - t1;
    chk(p > P2 - 0.5 && p < P2 + 0.5, "R9", "shift clock period", p, P2);
    wr_reg(8'h1A, 8'h02);
    #100; n = 0;
    for (int i = 0; i < 300; i++) begin #1.3; if (sclk_out) n++; end
    chk(n == 0, "R9", "shift clock gated off", n, 0);
  endtask

  task automatic t_restart;
    real tw, d, p;
    wr_reg(8'h1A, 8'h10);
    vid_period(p);
    @(negedge sys_clk); idx_wr = 1; wdata = 8'h1A;
    @(negedge sys_clk); idx_wr = 0; data_wr = 1; wdata = 8'h60;
    @(posedge sys_clk); tw = $realtime;
    @(negedge sys_clk); data_wr = 0;
    #(6 * P0);
    @(posedge vid_clk); d = $realtime - tw;
    chk(d > 33 * P0 && d < 38 * P0, "R6", "first edge after restart", d, 36 * P0);
    vid_period(p);
    chk(p > 64 * P0 - 0.5 && p < 64 * P0 + 0.5, "R6", "new ratio period", p, 64 * P0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1;
    t_reset();
    t_regport();
    t_sources();
    t_ratios();
    t_stuck();
    t_sclk();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule